// File: doc/BRIEF.md
# Port Change Mismatch Detector

This block watches the upper pins of an input port and raises a change flag when their present levels differ from a snapshot. The snapshot is taken each time the port is read. The pins arrive already synchronized. A read strobe loads the snapshot and returns the captured levels as read data. A software clear strobe tries to drop the flag. The enable gating and the interrupt routing sit in the controller above.

The block does not detect edges. It compares levels against the snapshot on every clock. While any pin disagrees with the snapshot, the flag is forced high on each edge, so a clear has no lasting effect. Only a port read, which moves the snapshot to the present pin levels, ends the mismatch so that a clear can succeed.

Read data leaves on a valid-only stream. `rd_valid` pulses for one cycle, one clock after each read strobe. There is no ready input and no back-pressure: every read is accepted, and the consumer must take the word in the cycle that `rd_valid` is high. The flag and the strobes are plain control pins.

Top module: `port_change_detect`

## Requirements
- R1: During and after reset, `chg_flag` is 0, `rd_valid` is 0 and `rd_data` (the snapshot) is all zeros. The port's flag has no defined power-on value; this block resets it to the parameter `FLAG_RST`, whose default is 0.
- R2: A `rd_stb` high at a clock edge loads the snapshot from `pins`. From the next cycle, `rd_data` shows those levels, with bit i of `rd_data` equal to bit i of `pins`. `rd_valid` is high for exactly the cycle after each strobe.
- R3: If any pin differs from the snapshot at a clock edge where `rd_stb` is low, `chg_flag` is 1 from the next cycle.
- R4: A `clr_stb` at an edge with no mismatch makes `chg_flag` 0 from the next cycle.
- R5: A `clr_stb` at an edge where a mismatch exists is overridden, and `chg_flag` stays 1.
- R6: When `rd_stb` and `clr_stb` are both high at the same edge, the comparison uses the snapshot being loaded, so `chg_flag` is 0 in the next cycle.
- R7: A pin that toggles and then returns to its snapshot level leaves `chg_flag` set.
- R8: Hardware never clears the flag. Without `clr_stb`, `chg_flag` holds its value, including across a read.
- R9: Each of the `NPINS` pins alone is able to set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | NPINS (4) | Synchronized upper port pins |
| rd_stb | input | 1 | Port read strobe; loads the snapshot |
| clr_stb | input | 1 | Software flag-clear strobe |
| rd_data | output | NPINS (4) | Snapshot taken by the last read |
| rd_valid | output | 1 | One-cycle pulse marking new read data |
| chg_flag | output | 1 | Change flag |

## Verification
A single-bit change with no strobe separates level comparison from no detection at all. A clear applied during that mismatch then shows that setting takes priority over clearing. A toggle that returns to the snapshot level separates this block from a plain comparator, since the flag must stay set after the pins match again. A read issued together with a clear checks that the freshly loaded snapshot is used for the comparison. A walk across each pin position alone catches a missing or swapped bit in the compare, and a read without a clear shows that a read alone never drops the flag.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int unsigned PMD_NPINS = 4;
  typedef logic [PMD_NPINS-1:0] pin_vec_t;
endpackage

// File: rtl/pmd_snapshot.sv
module pmd_snapshot #(
  parameter int unsigned NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic             load,
  output logic [NPINS-1:0] snap,
  output logic [NPINS-1:0] snap_eff
);
  always_ff @(posedge clk) begin
    if (!rst_n)    snap <= '0;
    else if (load) snap <= pins;
  end

  // Value the snapshot will hold after this edge; used for same-cycle compare
  assign snap_eff = load ? pins : snap;

  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> snap == $past(pins)); // R2
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap)); // R2
endmodule

// File: rtl/pmd_compare.sv
module pmd_compare #(
  parameter int unsigned NPINS = 4
) (
  input  logic [NPINS-1:0] ref_lvl,
  input  logic [NPINS-1:0] cur_lvl,
  output logic             mismatch
);
  logic [NPINS-1:0] diff;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    assign diff[i] = ref_lvl[i] ^ cur_lvl[i];
  end

  assign mismatch = |diff;
endmodule

// File: rtl/pmd_flag.sv
module pmd_flag #(
  parameter bit FLAG_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= FLAG_RST;
    else if (mismatch) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  AST_SET_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> flag); // R3
  AST_CLR_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && clr) |=> flag); // R5
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !mismatch) |=> !flag); // R4
  AST_NO_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R8
endmodule

// File: rtl/port_change_detect.sv
module port_change_detect
  import pmd_pkg::*;
#(
  parameter int unsigned NPINS    = PMD_NPINS,
  parameter bit          FLAG_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic             rd_stb,
  input  logic             clr_stb,
  output logic [NPINS-1:0] rd_data,
  output logic             rd_valid,
  output logic             chg_flag
);
  logic [NPINS-1:0] snap;
  logic [NPINS-1:0] snap_eff;
  logic             mismatch;

  pmd_snapshot #(.NPINS(NPINS)) u_snap (
    .clk(clk), .rst_n(rst_n), .pins(pins), .load(rd_stb),
    .snap(snap), .snap_eff(snap_eff)
  );

  pmd_compare #(.NPINS(NPINS)) u_cmp (
    .ref_lvl(snap_eff), .cur_lvl(pins), .mismatch(mismatch)
  );

  pmd_flag #(.FLAG_RST(FLAG_RST)) u_flag (
    .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .clr(clr_stb),
    .flag(chg_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_stb;
  end

  assign rd_data = snap;

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid); // R2
  AST_READ_CLEAR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && clr_stb) |=> !chg_flag); // R6
  AST_DIFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && (snap != pins)) |=> chg_flag); // R3
endmodule

// File: tb/port_change_detect_test.sv
module port_change_detect_test;
  localparam int NP = 4;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          rd_stb = 1'b0;
  logic          clr_stb = 1'b0;
  logic [NP-1:0] rd_data;
  logic          rd_valid;
  logic          chg_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // expected {chg_flag, rd_valid, rd_data} and requirement tag
  logic [NP+1:0] exp_q[$];
  string         tag_q[$];

  logic [NP-1:0] m_snap = '0;
  logic          m_flag = 1'b0;
  logic          m_valid = 1'b0;

  port_change_detect #(.NPINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .rd_stb(rd_stb),
    .clr_stb(clr_stb), .rd_data(rd_data), .rd_valid(rd_valid),
    .chg_flag(chg_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [NP+1:0] act,
                       input logic [NP+1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got flag/valid/data=%b expected %b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the model's expectation
  task automatic step(input logic [NP-1:0] p, input logic rd,
                      input logic clr, input string tag);
    logic [NP-1:0] eff;
    @(negedge clk);
    pins = p; rd_stb = rd; clr_stb = clr;
    @(posedge clk);
    eff = rd ? p : m_snap;
    if (|(eff ^ p)) m_flag = 1'b1;
    else if (clr)   m_flag = 1'b0;
    m_valid = rd;
    if (rd) m_snap = p;
    exp_q.push_back({m_flag, m_valid, m_snap});
    tag_q.push_back(tag);
  endtask

  // monitor: compare design outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [NP+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {chg_flag, rd_valid, rd_data}, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {chg_flag, rd_valid, rd_data}, '0);
    rst_n = 1'b1;

    step(4'h0, 1'b0, 1'b0, "R8");
    step(4'h1, 1'b0, 1'b0, "R3");
    step(4'h1, 1'b0, 1'b1, "R5");
    step(4'h1, 1'b1, 1'b1, "R6");
    step(4'h1, 1'b0, 1'b0, "R8");
    step(4'h1, 1'b0, 1'b0, "R2");
    step(4'h3, 1'b0, 1'b0, "R7");
    step(4'h1, 1'b0, 1'b0, "R7");
    step(4'h1, 1'b0, 1'b1, "R7");
    step(4'h1, 1'b0, 1'b1, "R4");
    for (int i = 0; i < NP; i++) begin
      logic [NP-1:0] pv;
      pv = 4'h1 ^ NP'(1 << i);
      step(pv, 1'b0, 1'b0, "R9");
      step(pv, 1'b1, 1'b1, "R6");
      step(4'h1, 1'b0, 1'b0, "R9");
      step(4'h1, 1'b1, 1'b0, "R8");
      step(4'h1, 1'b0, 1'b1, "R4");
    end
    step(4'hA, 1'b1, 1'b0, "R2");
    step(4'hA, 1'b0, 1'b0, "R2");
    step(4'h5, 1'b0, 1'b0, "R3");
    step(4'h5, 1'b0, 1'b1, "R5");
    step(4'h5, 1'b1, 1'b0, "R8");
    step(4'h5, 1'b0, 1'b1, "R4");
    step(4'h5, 1'b0, 1'b0, "R4");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule